// File: doc/BRIEF.md
# Opcode Predecoder with Cycle Count

This block sits ahead of the execute stage of an 8-bit processor core. It takes the opcode byte and the two bytes after it and works out the instruction's shape. That shape is the operation class, the addressing mode, the byte length, the operand assembled from the trailing bytes, and the base cycle count. It also takes two late hints from the fetch and branch logic: whether an indexed access or branch target crossed a 256-byte page, and whether a branch is taken. From these it produces the cycle count the instruction will really cost. Opcodes outside the documented set are flagged as illegal.

Decoding is combinational, and every output is registered once. A result appears at the outputs on the rising edge after the inputs are presented. The opcode table is not stored. It is computed from the three bit-fields of the opcode byte.

Top module: `opcode_predecoder`

## Requirements
- R1: While rst_n is low, every output is zero.
- R2: The outputs hold the decode of the inputs sampled at the previous rising clock edge. Changing the inputs between edges does not change the outputs.
- R3: Exactly 151 opcode values are legal. For any other value, illegal is 1, class is 0, mode is 0, length is 1, operand is 0 and both cycle counts are 0.
- R4: Mode codes are: implied 0, accumulator 1, immediate 2, zero page 3, zero page X 4, zero page Y 5, absolute 6, absolute X 7, absolute Y 8, indirect 9, indexed-indirect X 10, indirect-indexed Y 11, relative 12. The length is 1 for modes 0 and 1, 3 for modes 6 to 9, and 2 for all others.
- R5: With length 2, the operand is the second byte, zero-extended. With length 3, it is the third byte (high) above the second byte (low). With length 1, it is zero.
- R6: Class codes are: none 0, read 1, store 2, read-modify-write 3, branch 4, control transfer 5, stack push/pull 6, register/flag 7.
- R7: Base cycles include these values: 0x69 costs 2; 0x71 costs 5; 0xBD costs 4; 0x9D costs 5; 0x91 costs 6; 0x6C costs 5; 0x4C costs 3; 0x20 costs 6; 0x00 costs 7; 0xEA costs 2; and 0x1E, 0x3E, 0x5E, 0x7E each cost 7.
- R8: A read-class instruction in absolute X, absolute Y or indirect-indexed Y mode costs one extra cycle when page_cross is 1.
- R9: Store-class and read-modify-write-class instructions ignore page_cross. Their final count always equals the base count.
- R10: A branch costs 2 when not taken, whatever page_cross says. It costs 3 when taken, and 4 when taken with page_cross set.
- R11: branch_taken has no effect on any non-branch instruction. page_cross has no effect on control, stack, register or non-indexed read instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_byte | input | 8 | Opcode byte |
| arg_lo | input | 8 | Byte following the opcode |
| arg_hi | input | 8 | Second byte following the opcode |
| page_cross | input | 1 | Indexed address or branch target lies on another page |
| branch_taken | input | 1 | Branch condition is met |
| illegal | output | 1 | Opcode is not in the documented set |
| op_class | output | 3 | Operation class code (R6) |
| addr_mode | output | 4 | Addressing mode code (R4) |
| instr_len | output | 2 | Instruction length in bytes |
| operand | output | 16 | Assembled operand |
| base_cycles | output | 4 | Cycle count with no penalties |
| final_cycles | output | 4 | Cycle count after penalties |

## Verification
The bench walks all 256 opcodes under all four combinations of the two hints. It compares every output against a model organised by the low and high nibble of the opcode, not by the bit-fields the design uses. The sharpest corners are these:
- Stores in indexed modes must never pick up the read penalty. A design that applied the penalty by mode alone would report 6 for 0x9D.
- A branch that is not taken must ignore page_cross.
- The unused codes sit inside otherwise legal columns (0x89, 0x9E, 0x80), so a decoder that is too generous shows up as a wrong legal count.
- For operand assembly, any swap of the two bytes or leakage of the third byte into a two-byte operand is caught, because the second and third bytes differ on every opcode.

// File: rtl/pd_pkg.sv
package pd_pkg;

  localparam int BYTE_W = 8;
  localparam int OPD_W  = 2 * BYTE_W;

  typedef enum logic [2:0] {
    CLS_NONE   = 3'd0,
    CLS_READ   = 3'd1,
    CLS_STORE  = 3'd2,
    CLS_RMW    = 3'd3,
    CLS_BRANCH = 3'd4,
    CLS_CTRL   = 3'd5,
    CLS_STACK  = 3'd6,
    CLS_REG    = 3'd7
  } op_class_e;

  typedef enum logic [3:0] {
    AM_IMP = 4'd0,  AM_ACC = 4'd1,  AM_IMM = 4'd2,  AM_ZP  = 4'd3,
    AM_ZPX = 4'd4,  AM_ZPY = 4'd5,  AM_ABS = 4'd6,  AM_ABX = 4'd7,
    AM_ABY = 4'd8,  AM_IND = 4'd9,  AM_IZX = 4'd10, AM_IZY = 4'd11,
    AM_REL = 4'd12
  } addr_mode_e;

  typedef struct packed {
    logic       bad;
    op_class_e  cls;
    addr_mode_e mode;
    logic [3:0] base;
    logic       xpage;   // read that may pay a page-cross cycle
  } dec_t;

  localparam dec_t DEC_BAD = '{bad: 1'b1, cls: CLS_NONE, mode: AM_IMP,
                               base: 4'd0, xpage: 1'b0};

  function automatic dec_t ent(op_class_e c, addr_mode_e m, logic [3:0] cyc, logic xp);
    ent = '{bad: 1'b0, cls: c, mode: m, base: cyc, xpage: xp};
  endfunction

  // bytes occupied by opcode plus operand for a given mode
  function automatic logic [1:0] mode_len(addr_mode_e m);
    case (m)
      AM_IMP, AM_ACC:                 mode_len = 2'd1;
      AM_ABS, AM_ABX, AM_ABY, AM_IND: mode_len = 2'd3;
      default:                        mode_len = 2'd2;
    endcase
  endfunction

  // penalty cycles added on top of the base count
  function automatic logic [1:0] cyc_extra(op_class_e c, logic xp, logic pc, logic tk);
    if (c == CLS_READ && xp && pc)  cyc_extra = 2'd1;
    else if (c == CLS_BRANCH && tk) cyc_extra = pc ? 2'd2 : 2'd1;
    else                            cyc_extra = 2'd0;
  endfunction

endpackage

// File: rtl/pd_opdecode.sv
module pd_opdecode
  import pd_pkg::*;
(
  input  logic [7:0] op,
  output dec_t       dec
);
  logic [2:0] aaa, bbb;
  logic [1:0] cc;
  assign aaa = op[7:5];
  assign bbb = op[4:2];
  assign cc  = op[1:0];

  addr_mode_e g1_mode;
  logic [3:0] g1_rd, g1_st;
  logic       g1_xp;

  // arithmetic/logic column: mode and costs depend only on bbb
  always_comb begin
    g1_xp = 1'b0;
    case (bbb)
      3'd0:    begin g1_mode = AM_IZX; g1_rd = 4'd6; g1_st = 4'd6; end
      3'd1:    begin g1_mode = AM_ZP;  g1_rd = 4'd3; g1_st = 4'd3; end
      3'd2:    begin g1_mode = AM_IMM; g1_rd = 4'd2; g1_st = 4'd2; end
      3'd3:    begin g1_mode = AM_ABS; g1_rd = 4'd4; g1_st = 4'd4; end
      3'd4:    begin g1_mode = AM_IZY; g1_rd = 4'd5; g1_st = 4'd6; g1_xp = 1'b1; end
      3'd5:    begin g1_mode = AM_ZPX; g1_rd = 4'd4; g1_st = 4'd4; end
      3'd6:    begin g1_mode = AM_ABY; g1_rd = 4'd4; g1_st = 4'd5; g1_xp = 1'b1; end
      default: begin g1_mode = AM_ABX; g1_rd = 4'd4; g1_st = 4'd5; g1_xp = 1'b1; end
    endcase
  end

  logic is_stx, is_ldx, is_rmw;
  assign is_stx = (aaa == 3'd4);
  assign is_ldx = (aaa == 3'd5);
  assign is_rmw = !is_stx && !is_ldx;

  always_comb begin
    dec = DEC_BAD;
    case (cc)
      2'b01: begin
        if (is_stx) begin
          if (bbb != 3'd2) dec = ent(CLS_STORE, g1_mode, g1_st, 1'b0);
        end else begin
          dec = ent(CLS_READ, g1_mode, g1_rd, g1_xp);
        end
      end
      2'b10: begin
        case (bbb)
          3'd0: if (is_ldx) dec = ent(CLS_READ, AM_IMM, 4'd2, 1'b0);
          3'd1: dec = is_rmw ? ent(CLS_RMW, AM_ZP, 4'd5, 1'b0)
                    : ent(is_stx ? CLS_STORE : CLS_READ, AM_ZP, 4'd3, 1'b0);
          3'd2: dec = ent(CLS_REG, aaa[2] ? AM_IMP : AM_ACC, 4'd2, 1'b0);
          3'd3: dec = is_rmw ? ent(CLS_RMW, AM_ABS, 4'd6, 1'b0)
                    : ent(is_stx ? CLS_STORE : CLS_READ, AM_ABS, 4'd4, 1'b0);
          3'd5: dec = is_rmw ? ent(CLS_RMW, AM_ZPX, 4'd6, 1'b0)
                    : ent(is_stx ? CLS_STORE : CLS_READ, AM_ZPY, 4'd4, 1'b0);
          3'd6: if (!is_rmw) dec = ent(CLS_REG, AM_IMP, 4'd2, 1'b0);
          3'd7: begin
            if (is_rmw)      dec = ent(CLS_RMW, AM_ABX, 4'd7, 1'b0);
            else if (is_ldx) dec = ent(CLS_READ, AM_ABY, 4'd4, 1'b1);
          end
          default: dec = DEC_BAD;
        endcase
      end
      2'b00: begin
        case (bbb)
          3'd0: begin
            case (aaa)
              3'd0:    dec = ent(CLS_CTRL, AM_IMP, 4'd7, 1'b0);
              3'd1:    dec = ent(CLS_CTRL, AM_ABS, 4'd6, 1'b0);
              3'd2,
              3'd3:    dec = ent(CLS_CTRL, AM_IMP, 4'd6, 1'b0);
              3'd4:    dec = DEC_BAD;
              default: dec = ent(CLS_READ, AM_IMM, 4'd2, 1'b0);
            endcase
          end
          3'd1: begin
            if (aaa == 3'd4)                     dec = ent(CLS_STORE, AM_ZP, 4'd3, 1'b0);
            else if (aaa == 3'd1 || aaa >= 3'd5) dec = ent(CLS_READ, AM_ZP, 4'd3, 1'b0);
          end
          3'd2: dec = aaa[2] ? ent(CLS_REG, AM_IMP, 4'd2, 1'b0)
                    : ent(CLS_STACK, AM_IMP, aaa[0] ? 4'd4 : 4'd3, 1'b0);
          3'd3: begin
            case (aaa)
              3'd0:    dec = DEC_BAD;
              3'd2:    dec = ent(CLS_CTRL, AM_ABS, 4'd3, 1'b0);
              3'd3:    dec = ent(CLS_CTRL, AM_IND, 4'd5, 1'b0);
              3'd4:    dec = ent(CLS_STORE, AM_ABS, 4'd4, 1'b0);
              default: dec = ent(CLS_READ, AM_ABS, 4'd4, 1'b0);
            endcase
          end
          3'd4: dec = ent(CLS_BRANCH, AM_REL, 4'd2, 1'b0);
          3'd5: begin
            if (aaa == 3'd4)      dec = ent(CLS_STORE, AM_ZPX, 4'd4, 1'b0);
            else if (aaa == 3'd5) dec = ent(CLS_READ, AM_ZPX, 4'd4, 1'b0);
          end
          3'd6: dec = ent(CLS_REG, AM_IMP, 4'd2, 1'b0);
          default: if (aaa == 3'd5) dec = ent(CLS_READ, AM_ABX, 4'd4, 1'b1);
        endcase
      end
      default: dec = DEC_BAD;
    endcase
  end
endmodule

// File: rtl/pd_operand.sv
module pd_operand
  import pd_pkg::*;
#(
  parameter int LANES = 2
) (
  input  addr_mode_e              mode,
  input  logic [BYTE_W-1:0]       b1,
  input  logic [BYTE_W-1:0]       b2,
  output logic [1:0]              len,
  output logic [LANES*BYTE_W-1:0] opd
);
  logic [BYTE_W-1:0] lane_in [LANES];
  assign lane_in[0] = b1;
  assign lane_in[1] = b2;
  assign len = mode_len(mode);

  // lane k is present once the instruction is longer than k+1 bytes
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign opd[k*BYTE_W +: BYTE_W] = (len > 2'(k + 1)) ? lane_in[k] : '0;
  end
endmodule

// File: rtl/pd_cycle_adj.sv
module pd_cycle_adj
  import pd_pkg::*;
#(
  parameter int CYC_W = 4
) (
  input  dec_t             dec,
  input  logic             page_cross,
  input  logic             taken,
  output logic [CYC_W-1:0] final_cyc,
  output logic             read_pen_hit,
  output logic             branch_hit,
  output logic             branch_far_hit
);
  logic [1:0] extra;
  assign extra          = cyc_extra(dec.cls, dec.xpage, page_cross, taken);
  assign read_pen_hit   = (dec.cls == CLS_READ) && (extra != 2'd0);
  assign branch_hit     = (dec.cls == CLS_BRANCH) && (extra != 2'd0);
  assign branch_far_hit = branch_hit && (extra == 2'd2);
  assign final_cyc      = CYC_W'(dec.base) + CYC_W'(extra);
endmodule

// File: rtl/opcode_predecoder.sv
module opcode_predecoder
  import pd_pkg::*;
#(
  parameter int CYC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        op_byte,
  input  logic [7:0]        arg_lo,
  input  logic [7:0]        arg_hi,
  input  logic              page_cross,
  input  logic              branch_taken,
  output logic              illegal,
  output logic [2:0]        op_class,
  output logic [3:0]        addr_mode,
  output logic [1:0]        instr_len,
  output logic [OPD_W-1:0]  operand,
  output logic [CYC_W-1:0]  base_cycles,
  output logic [CYC_W-1:0]  final_cycles
);
  dec_t             dec;
  logic [1:0]       len_c;
  logic [OPD_W-1:0] opd_c;
  logic [CYC_W-1:0] fin_c;
  logic             read_pen_hit, branch_hit, branch_far_hit;

  pd_opdecode u_dec (.op(op_byte), .dec(dec));

  pd_operand #(.LANES(2)) u_opd (
    .mode(dec.mode), .b1(arg_lo), .b2(arg_hi), .len(len_c), .opd(opd_c)
  );

  pd_cycle_adj #(.CYC_W(CYC_W)) u_cyc (
    .dec(dec), .page_cross(page_cross), .taken(branch_taken),
    .final_cyc(fin_c), .read_pen_hit(read_pen_hit),
    .branch_hit(branch_hit), .branch_far_hit(branch_far_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      illegal      <= 1'b0;
      op_class     <= '0;
      addr_mode    <= '0;
      instr_len    <= '0;
      operand      <= '0;
      base_cycles  <= '0;
      final_cycles <= '0;
    end else begin
      illegal      <= dec.bad;
      op_class     <= dec.cls;
      addr_mode    <= dec.mode;
      instr_len    <= len_c;
      operand      <= opd_c;
      base_cycles  <= CYC_W'(dec.base);
      final_cycles <= fin_c;
    end
  end

  // R3
  illegal_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (instr_len == 2'd1 && final_cycles == '0 && op_class == 3'd0 && operand == '0));

  // R5
  short_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_len == 2'd2) |-> (operand[15:8] == 8'h00));

  // R5
  no_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_len == 2'd1) |-> (operand == '0));

  // R8
  read_penalty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_pen_hit |=> (final_cycles == base_cycles + 1'b1 && op_class == 3'd1));

  // R9
  fixed_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == 3'd2 || op_class == 3'd3) |-> (final_cycles == base_cycles));

  // R10
  branch_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == 3'd4) |-> (instr_len == 2'd2 && base_cycles == 4'd2 && addr_mode == 4'd12));

  // R10
  branch_far_chk: assert property (@(posedge clk) disable iff (!rst_n)
    branch_far_hit |=> (final_cycles == 4'd4));

  // R10
  branch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!branch_hit && !read_pen_hit) |=> (final_cycles == base_cycles));

  // R11
  hint_blind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class >= 3'd5) |-> (final_cycles == base_cycles));
endmodule

// File: tb/test_opcode_predecoder.sv
module test_opcode_predecoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  op_byte = 8'h00, arg_lo = 8'h00, arg_hi = 8'h00;
  logic        page_cross = 1'b0, branch_taken = 1'b0;
  logic        illegal;
  logic [2:0]  op_class;
  logic [3:0]  addr_mode;
  logic [1:0]  instr_len;
  logic [15:0] operand;
  logic [3:0]  base_cycles, final_cycles;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  opcode_predecoder i_opcode_predecoder (
    .clk(clk), .rst_n(rst_n), .op_byte(op_byte), .arg_lo(arg_lo), .arg_hi(arg_hi),
    .page_cross(page_cross), .branch_taken(branch_taken), .illegal(illegal),
    .op_class(op_class), .addr_mode(addr_mode), .instr_len(instr_len),
    .operand(operand), .base_cycles(base_cycles), .final_cycles(final_cycles)
  );

  // expected record: {bad, cls[2:0], mode[3:0], base[3:0], xp}
  function automatic logic [12:0] mk(logic [2:0] c, logic [3:0] m, logic [3:0] b, logic xp);
    mk = {1'b0, c, m, b, xp};
  endfunction

  localparam logic [12:0] BAD = 13'h1000;

  // model organised by low/high nibble of the opcode
  function automatic logic [12:0] model(logic [7:0] op);
    logic [3:0] hi = op[7:4];
    logic [3:0] lo = op[3:0];
    logic odd = hi[0];
    model = BAD;
    case (lo)
      4'h0: if (odd) model = mk(4, 12, 2, 0);
            else case (hi)
              4'h0: model = mk(5, 0, 7, 0);
              4'h2: model = mk(5, 6, 6, 0);
              4'h4, 4'h6: model = mk(5, 0, 6, 0);
              4'hA, 4'hC, 4'hE: model = mk(1, 2, 2, 0);
              default: model = BAD;
            endcase
      4'h1: if (hi == 4'h8 || hi == 4'h9) model = mk(2, odd ? 11 : 10, 6, 0);
            else model = odd ? mk(1, 11, 5, 1) : mk(1, 10, 6, 0);
      4'h2: if (hi == 4'hA) model = mk(1, 2, 2, 0);
      4'h4: case (hi)
              4'h2, 4'hA, 4'hC, 4'hE: model = mk(1, 3, 3, 0);
              4'h8: model = mk(2, 3, 3, 0);
              4'h9: model = mk(2, 4, 4, 0);
              4'hB: model = mk(1, 4, 4, 0);
              default: model = BAD;
            endcase
      4'h5: if (hi == 4'h8) model = mk(2, 3, 3, 0);
            else if (hi == 4'h9) model = mk(2, 4, 4, 0);
            else model = odd ? mk(1, 4, 4, 0) : mk(1, 3, 3, 0);
      4'h6: case (hi)
              4'h8: model = mk(2, 3, 3, 0);
              4'h9: model = mk(2, 5, 4, 0);
              4'hA: model = mk(1, 3, 3, 0);
              4'hB: model = mk(1, 5, 4, 0);
              default: model = odd ? mk(3, 4, 6, 0) : mk(3, 3, 5, 0);
            endcase
      4'h8: case (hi)
              4'h0, 4'h4: model = mk(6, 0, 3, 0);
              4'h2, 4'h6: model = mk(6, 0, 4, 0);
              default: model = mk(7, 0, 2, 0);
            endcase
      4'h9: if (!odd) model = (hi == 4'h8) ? BAD : mk(1, 2, 2, 0);
            else model = (hi == 4'h9) ? mk(2, 8, 5, 0) : mk(1, 8, 4, 1);
      4'hA: if (!odd) model = mk(7, (hi < 4'h8) ? 4'd1 : 4'd0, 2, 0);
            else if (hi == 4'h9 || hi == 4'hB) model = mk(7, 0, 2, 0);
      4'hC: case (hi)
              4'h2, 4'hA, 4'hC, 4'hE: model = mk(1, 6, 4, 0);
              4'h4: model = mk(5, 6, 3, 0);
              4'h6: model = mk(5, 9, 5, 0);
              4'h8: model = mk(2, 6, 4, 0);
              4'hB: model = mk(1, 7, 4, 1);
              default: model = BAD;
            endcase
      4'hD: if (!odd) model = (hi == 4'h8) ? mk(2, 6, 4, 0) : mk(1, 6, 4, 0);
            else model = (hi == 4'h9) ? mk(2, 7, 5, 0) : mk(1, 7, 4, 1);
      4'hE: if (!odd) begin
              if (hi == 4'h8) model = mk(2, 6, 4, 0);
              else if (hi == 4'hA) model = mk(1, 6, 4, 0);
              else model = mk(3, 6, 6, 0);
            end else begin
              if (hi == 4'h9) model = BAD;
              else if (hi == 4'hB) model = mk(1, 8, 4, 1);
              else model = mk(3, 7, 7, 0);
            end
      default: model = BAD;
    endcase
  endfunction

  function automatic logic [1:0] exp_len(logic [3:0] m);
    if (m <= 4'd1) exp_len = 2'd1;
    else if (m >= 4'd6 && m <= 4'd9) exp_len = 2'd3;
    else exp_len = 2'd2;
  endfunction

  task automatic drive(logic [7:0] op, logic [7:0] lo, logic [7:0] hi, logic pc, logic tk);
    @(negedge clk);
    op_byte = op; arg_lo = lo; arg_hi = hi; page_cross = pc; branch_taken = tk;
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, logic [7:0] op);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%02h actual=%0h expected=%0h", req, op, act, exp);
    end
  endtask

  // full comparison of every output against the model
  task automatic sweep_one(logic [7:0] op, logic pc, logic tk);
    logic [12:0] e;
    logic [7:0] b1, b2;
    logic [1:0] len;
    logic [15:0] opd;
    logic [3:0] fin;
    b1 = op ^ 8'h5A;
    b2 = op + 8'h33;
    drive(op, b1, b2, pc, tk);
    e = model(op);
    len = e[12] ? 2'd1 : exp_len(e[8:5]);
    opd = (len == 2'd3) ? {b2, b1} : (len == 2'd2) ? {8'h00, b1} : 16'h0000;
    fin = e[4:1];
    if (e[11:9] == 3'd1 && e[0] && pc) fin = fin + 4'd1;        // R8
    if (e[11:9] == 3'd4 && tk) fin = fin + (pc ? 4'd2 : 4'd1);  // R10
    check("R3/R6/R4", {illegal, op_class, addr_mode, base_cycles},
          {e[12], e[11:9], e[8:5], e[4:1]}, op);
    check("R4/R5", {instr_len, operand}, {len, opd}, op);
    check("R8/R9/R10/R11", final_cycles, fin, op);
  endtask

  task automatic spot(logic [7:0] op, logic pc, logic tk, logic [3:0] eb, logic [3:0] ef, string req);
    drive(op, 8'h12, 8'h34, pc, tk);
    check(req, {base_cycles, final_cycles}, {eb, ef}, op);
  endtask

  initial begin
    int legal;
    // R1: reset state
    repeat (2) @(negedge clk);
    op_byte = 8'hBD; arg_lo = 8'hFF; arg_hi = 8'hEE; page_cross = 1'b1;
    @(negedge clk);
    check("R1", {illegal, op_class, addr_mode, instr_len, operand, base_cycles, final_cycles}, 0, 8'hBD);
    rst_n = 1'b1;

    // R2: latency, output holds until the next edge
    drive(8'hA9, 8'h77, 8'h00, 1'b0, 1'b0);
    op_byte = 8'h6D; arg_lo = 8'h01; arg_hi = 8'h02;
    #1;
    check("R2", {instr_len, operand}, {2'd2, 16'h0077}, 8'hA9);
    @(negedge clk);
    check("R2", {instr_len, operand}, {2'd3, 16'h0201}, 8'h6D);

    // R3..R11: exhaustive sweep
    legal = 0;
    for (int op = 0; op < 256; op++) begin
      for (int h = 0; h < 4; h++) sweep_one(8'(op), h[0], h[1]);
      if (!illegal) legal++;
    end
    check("R3 legal count", legal, 151, 8'h00);

    // R7 named costs
    spot(8'h69, 0, 0, 4'd2, 4'd2, "R7");
    spot(8'h71, 1, 0, 4'd5, 4'd6, "R7/R8");
    spot(8'hBD, 1, 1, 4'd4, 4'd5, "R7/R8");
    spot(8'h9D, 1, 0, 4'd5, 4'd5, "R7/R9");
    spot(8'h91, 1, 0, 4'd6, 4'd6, "R7/R9");
    spot(8'h6C, 1, 1, 4'd5, 4'd5, "R7/R11");
    spot(8'h4C, 0, 1, 4'd3, 4'd3, "R7/R11");
    spot(8'h20, 0, 0, 4'd6, 4'd6, "R7");
    spot(8'h00, 0, 0, 4'd7, 4'd7, "R7");
    spot(8'hEA, 1, 1, 4'd2, 4'd2, "R7/R11");
    for (int k = 0; k < 4; k++) spot(8'(8'h1E + 8'(k) * 8'h20), 1, 0, 4'd7, 4'd7, "R7/R9");
    spot(8'hD0, 1, 0, 4'd2, 4'd2, "R10");
    spot(8'hD0, 0, 1, 4'd2, 4'd3, "R10");
    spot(8'hD0, 1, 1, 4'd2, 4'd4, "R10");
    spot(8'hAD, 1, 1, 4'd4, 4'd4, "R11");
    spot(8'h89, 1, 1, 4'd0, 4'd0, "R3");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule